// File: doc/BRIEF.md
# Two-Port Hashed Bank Steering Front End

This block sits in front of a cache data array that is split into several single-ported banks. Two requesters may each present one read or write per cycle. The block maps each request's line address to a bank. By default it folds two low tag bits into the bank-select bits with XOR, so that strided streams spread across the banks. Requests that land in different banks are issued to their banks in the same cycle.

When both requests map to the same bank, one is issued and the other sees its ready signal low. That requester keeps presenting the request, which wins on the next cycle, so no request is lost and none can starve. Each accepted request produces exactly one response on its own port, one cycle after acceptance. Because every access takes the same fixed time, responses on a port come back in the order the requests were accepted. The response carries the tag that came with the request.

The bank arrays are plain synchronous RAMs inside the block. A parameter turns hashing off, which gives plain block interleaving.

Top module: `bank_steer`

## Requirements
- R1: With HASH_EN=0 the bank of a request is its line address modulo the bank count; with the default widths (8-byte lines, 4 banks) this is address bits [4:3].
- R2: With HASH_EN=1 the bank is the line-address bank bits XOR the two line-address bits that sit SET_W bits above them; with the defaults this is addr[4:3] XOR addr[10:9].
- R3: When both ports are valid and map to different banks, both ready outputs are high in that cycle.
- R4: When both ports are valid and map to the same bank, exactly one ready output is high.
- R5: In a same-bank collision where neither request was refused in the previous cycle, port 0 is served.
- R6: A request that was refused in a cycle and is presented again in the next cycle is served in that cycle, even if it collides with a fresh request on the other port.
- R7: A request accepted (valid and ready high at a clock edge) gives rsp_valid high on the same port for exactly the following cycle, with rsp_tag equal to the request's tag; no response appears without an accepted request.
- R8: A read returns the data most recently written to the same line through either port; a write's response returns the written data.
- R9: During and immediately after reset no response is valid, and no request is treated as held over.
- R10: With both ports issuing uniformly random lines to 4 banks, roughly one quarter of fresh request pairs collide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Request present, one bit per port |
| req_ready | output | 2 | Request accepted this cycle, one bit per port |
| req_write | input | 2 | 1 = write, 0 = read, per port |
| req_addr | input | 2 x ADDR_W | Byte address per port |
| req_wdata | input | 2 x DATA_W | Write data per port |
| req_tag | input | 2 x TAG_W | Requester tag, echoed in the response |
| rsp_valid | output | 2 | Response present, per port |
| rsp_data | output | 2 x DATA_W | Read data, or written data for a write |
| rsp_tag | output | 2 x TAG_W | Tag of the request being answered |

## Verification
On every clock, the properties check the bank-level arbitration. Split-bank pairs must both proceed, a collision must let exactly one through, port 0 must win a fresh tie, and a refused request must win on its retry. They also check that each acceptance yields one response with the matching tag one cycle later. Only the bench scenarios can show that the hash and linear mappings pick the intended banks, since the bench recomputes both mappings from the address bits. The same holds for data integrity across writes and reads through both ports, and for the measured collision rate under random traffic.

// File: rtl/bank_steer_pkg.sv
`timescale 1ns/1ps
package bank_steer_pkg;

  // Fold the line address into a bank number; optionally XOR in the
  // low tag bits located skip_w bits above the bank field.
  function automatic logic [7:0] fold_bank(input logic [31:0] line,
                                           input int unsigned bank_w,
                                           input int unsigned skip_w,
                                           input logic hash_on);
    logic [31:0] mask;
    logic [31:0] low;
    logic [31:0] upper;
    mask  = (32'd1 << bank_w) - 32'd1;
    low   = line & mask;
    upper = (line >> (bank_w + skip_w)) & mask;
    fold_bank = hash_on ? low[7:0] ^ upper[7:0] : low[7:0];
  endfunction

  // Row inside a bank: every line bit above the bank field that the
  // bank storage resolves (set bits plus the hashed tag bits).
  function automatic logic [15:0] row_in_bank(input logic [31:0] line,
                                              input int unsigned bank_w,
                                              input int unsigned row_w);
    logic [31:0] shifted;
    shifted = (line >> bank_w) & ((32'd1 << row_w) - 32'd1);
    row_in_bank = shifted[15:0];
  endfunction

endpackage

// File: rtl/bank_steer_ram.sv
`timescale 1ns/1ps
module bank_steer_ram #(
  parameter int ROW_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int ROWS = 1 << ROW_W;

  logic [DATA_W-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        cells[row] <= wdata;
        rdata      <= wdata;
      end else begin
        rdata <= cells[row];
      end
    end
  end
endmodule

// File: rtl/bank_steer_arb.sv
`timescale 1ns/1ps
module bank_steer_arb #(
  parameter int BANK_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             valid,
  input  logic [1:0][BANK_W-1:0] bank,
  output logic [1:0]             ready,
  output logic [1:0]             grant,
  output logic                   collide,
  output logic [1:0]             held_q
);
  logic older_is_p1;

  assign collide     = valid[0] && valid[1] && (bank[0] == bank[1]);
  // Only the loser of a collision is held, so at most one bit is set.
  assign older_is_p1 = held_q[1];

  always_comb begin
    ready[0] = !collide || !older_is_p1;
    ready[1] = !collide ||  older_is_p1;
  end

  assign grant = valid & ready;

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= valid & ~ready;
  end
endmodule

// File: rtl/bank_steer.sv
`timescale 1ns/1ps
module bank_steer #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 4,
  parameter int OFF_W   = 3,
  parameter int N_BANKS = 4,
  parameter int SET_W   = 4,
  parameter bit HASH_EN = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             req_valid,
  output logic [1:0]             req_ready,
  input  logic [1:0]             req_write,
  input  logic [1:0][ADDR_W-1:0] req_addr,
  input  logic [1:0][DATA_W-1:0] req_wdata,
  input  logic [1:0][TAG_W-1:0]  req_tag,
  output logic [1:0]             rsp_valid,
  output logic [1:0][DATA_W-1:0] rsp_data,
  output logic [1:0][TAG_W-1:0]  rsp_tag
);
  import bank_steer_pkg::*;

  localparam int BANK_W = $clog2(N_BANKS);
  localparam int ROW_W  = SET_W + BANK_W;
  localparam int LINE_W = ADDR_W - OFF_W;

  logic [1:0][BANK_W-1:0]        port_bank;
  logic [1:0][ROW_W-1:0]         port_row;
  logic [1:0]                    port_grant;
  logic                          collide;
  logic [1:0]                    held_q;
  logic [N_BANKS-1:0]            bank_en;
  logic [N_BANKS-1:0][DATA_W-1:0] bank_rdata;
  logic [1:0][BANK_W-1:0]        rsp_bank_q;

  // Address decode per port
  for (genvar p = 0; p < 2; p++) begin : g_decode
    logic [LINE_W-1:0] line;
    logic [7:0]        bank_full;
    logic [15:0]       row_full;
    assign line          = req_addr[p][ADDR_W-1:OFF_W];
    assign bank_full     = fold_bank(32'(line), BANK_W, SET_W, HASH_EN);
    assign row_full      = row_in_bank(32'(line), BANK_W, ROW_W);
    assign port_bank[p]  = bank_full[BANK_W-1:0];
    assign port_row[p]   = row_full[ROW_W-1:0];
  end

  bank_steer_arb #(.BANK_W(BANK_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (req_valid),
    .bank    (port_bank),
    .ready   (req_ready),
    .grant   (port_grant),
    .collide (collide),
    .held_q  (held_q)
  );

  // Bank arrays, each driven by whichever port was granted to it
  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic hit0;
    logic hit1;
    logic [ROW_W-1:0]  row_sel;
    logic [DATA_W-1:0] wdata_sel;
    logic              we_sel;
    assign hit0      = port_grant[0] && (port_bank[0] == BANK_W'(b));
    assign hit1      = port_grant[1] && (port_bank[1] == BANK_W'(b));
    assign bank_en[b] = hit0 || hit1;
    assign row_sel   = hit1 ? port_row[1]  : port_row[0];
    assign wdata_sel = hit1 ? req_wdata[1] : req_wdata[0];
    assign we_sel    = hit1 ? req_write[1] : req_write[0];

    bank_steer_ram #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .en    (bank_en[b]),
      .we    (we_sel),
      .row   (row_sel),
      .wdata (wdata_sel),
      .rdata (bank_rdata[b])
    );
  end

  // Response stage: fixed one-cycle latency keeps each port in order
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= '0;
      rsp_tag    <= '0;
      rsp_bank_q <= '0;
    end else begin
      rsp_valid <= port_grant;
      for (int p = 0; p < 2; p++) begin
        if (port_grant[p]) begin
          rsp_tag[p]    <= req_tag[p];
          rsp_bank_q[p] <= port_bank[p];
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < 2; p++) rsp_data[p] = bank_rdata[rsp_bank_q[p]];
  end
endmodule

// File: rtl/bank_steer_chk.sv
`timescale 1ns/1ps
module bank_steer_chk #(
  parameter int TAG_W  = 4,
  parameter int BANK_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             req_valid,
  input logic [1:0]             req_ready,
  input logic [1:0][TAG_W-1:0]  req_tag,
  input logic [1:0]             rsp_valid,
  input logic [1:0][TAG_W-1:0]  rsp_tag,
  input logic [1:0][BANK_W-1:0] port_bank,
  input logic                   collide,
  input logic [1:0]             held_q
);
  p_split_banks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == 2'b11 && port_bank[0] != port_bank[1]) |-> req_ready == 2'b11);

  p_single_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == 2'b11 && port_bank[0] == port_bank[1]) |-> $countones(req_ready) == 1);

  p_port0_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && held_q == 2'b00) |-> req_ready[0]);

  for (genvar p = 0; p < 2; p++) begin : g_port
    p_retry_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && !req_ready[p]) |=> (!req_valid[p] || req_ready[p]));

    p_rsp_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && req_ready[p]) |=> (rsp_valid[p] && rsp_tag[p] == $past(req_tag[p])));

    p_no_stray_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid[p] && req_ready[p]) |=> !rsp_valid[p]);
  end
endmodule

bind bank_steer bank_steer_chk #(.TAG_W(TAG_W), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/bank_steer_test.sv
`timescale 1ns/1ps
module bank_steer_test;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                   rst_n;
  logic [1:0]             req_valid;
  logic [1:0]             req_write;
  logic [1:0][ADDR_W-1:0] req_addr;
  logic [1:0][DATA_W-1:0] req_wdata;
  logic [1:0][TAG_W-1:0]  req_tag;
  logic [1:0]             req_ready, pl_ready;
  logic [1:0]             rsp_valid, pl_rsp_valid;
  logic [1:0][DATA_W-1:0] rsp_data, pl_rsp_data;
  logic [1:0][TAG_W-1:0]  rsp_tag, pl_rsp_tag;

  bank_steer #(.HASH_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag));

  bank_steer #(.HASH_EN(1'b0)) uut_plain (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(pl_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_tag(req_tag), .rsp_valid(pl_rsp_valid), .rsp_data(pl_rsp_data), .rsp_tag(pl_rsp_tag));

  typedef struct {
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
    int                due;
  } exp_t;

  exp_t q0[$];
  exp_t q1[$];
  logic [DATA_W-1:0] shadow [0:8191];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;
  int fresh_pairs = 0;
  int fresh_coll  = 0;

  // pending requests owned by the requester model
  logic [1:0]             pv, pw;
  logic [1:0][ADDR_W-1:0] pa;
  logic [1:0][DATA_W-1:0] pd;
  logic [1:0][TAG_W-1:0]  pt;
  logic [1:0]             hold_h, hold_n;

  // bank mapping restated from R1/R2: addr[4:3], optionally ^ addr[10:9]
  function automatic int bank_of(input logic [ADDR_W-1:0] a, input bit hashed);
    int lo, hi;
    lo = int'(a[4:3]);
    hi = int'(a[10:9]);
    return hashed ? (lo ^ hi) : lo;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: one clock of presentation, readiness checks, scoreboard push
  task automatic step();
    bit coll_h, coll_n;
    logic [1:0] er_h, er_n;
    string tag_h;
    @(negedge clk);
    req_valid = pv; req_write = pw; req_addr = pa; req_wdata = pd; req_tag = pt;
    #1;
    coll_h = pv == 2'b11 && bank_of(pa[0], 1) == bank_of(pa[1], 1);
    coll_n = pv == 2'b11 && bank_of(pa[0], 0) == bank_of(pa[1], 0);
    // older request wins, otherwise port 0
    er_h = coll_h ? (hold_h[1] ? 2'b10 : 2'b01) : 2'b11;
    er_n = coll_n ? (hold_n[1] ? 2'b10 : 2'b01) : 2'b11;
    tag_h = !coll_h ? "R2/R3" : (hold_h != 0 ? "R6" : "R5");
    check(req_ready == er_h, tag_h, "hashed ready", req_ready, er_h);
    check(pl_ready == er_n, coll_n ? "R1/R4" : "R1/R3", "linear ready", pl_ready, er_n);
    if (coll_h) check($countones(req_ready) == 1, "R4", "one winner", req_ready, 1);
    if (pv == 2'b11 && hold_h == 2'b00) begin
      fresh_pairs++;
      if (coll_h) fresh_coll++;
    end
    hold_h = pv & ~req_ready;
    hold_n = pv & ~pl_ready;
    for (int p = 0; p < 2; p++) begin
      if (pv[p] && req_ready[p]) begin
        exp_t e;
        e.tag = pt[p];
        e.due = cyc + 1;
        if (pw[p]) begin
          shadow[pa[p][15:3]] = pd[p];
          e.data = pd[p];
        end else begin
          e.data = shadow[pa[p][15:3]];
        end
        if (p == 0) q0.push_back(e); else q1.push_back(e);
        pv[p] = 1'b0;
      end
    end
  endtask

  task automatic drain();
    while (pv != 2'b00) step();
    pv = 2'b00;
    step();
  endtask

  task automatic set_req(input int p, input bit w, input int line,
                         input logic [DATA_W-1:0] d, input logic [TAG_W-1:0] t);
    pv[p] = 1'b1; pw[p] = w; pa[p] = ADDR_W'(line << 3); pd[p] = d; pt[p] = t;
  endtask

  // Monitor: compare responses against the scoreboard
  task automatic mon_port(input int p, ref exp_t q[$]);
    if (rsp_valid[p]) begin
      if (q.size() == 0) begin
        check(0, "R7", $sformatf("port%0d unexpected response", p), 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.due == cyc, "R7", $sformatf("port%0d response cycle", p), cyc, e.due);
        check(rsp_tag[p] == e.tag, "R7", $sformatf("port%0d tag", p), rsp_tag[p], e.tag);
        check(rsp_data[p] == e.data, "R8", $sformatf("port%0d data", p), rsp_data[p], e.data);
      end
    end else if (q.size() != 0 && q[0].due <= cyc) begin
      check(0, "R7", $sformatf("port%0d missing response", p), 0, 1);
      void'(q.pop_front());
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #5;
    if (rst_n) begin
      mon_port(0, q0);
      mon_port(1, q1);
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    pv = '0; pw = '0; pa = '0; pd = '0; pt = '0;
    hold_h = '0; hold_n = '0;
    req_valid = '0; req_write = '0; req_addr = '0; req_wdata = '0; req_tag = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check(rsp_valid == 2'b00, "R9", "rsp_valid in reset", rsp_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(rsp_valid == 2'b00, "R9", "rsp_valid after reset", rsp_valid, 0);
    check(req_ready == 2'b11, "R9", "ready idle after reset", req_ready, 3);

    // Fill lines 0..255: pairs i and i+128 differ only in a hashed tag bit
    for (int i = 0; i < 128; i++) begin
      set_req(0, 1, i,       32'hA500_0000 + i,       TAG_W'(i));
      set_req(1, 1, i + 128, 32'h5A00_0000 + i + 128, TAG_W'(i + 1));
      while (pv != 2'b00) step();
    end
    drain();

    // Fresh collision then retry priority: lines 0,4,8 all hash to bank 0
    set_req(0, 0, 0, '0, 4'h1);
    set_req(1, 0, 4, '0, 4'h2);
    step();
    check(pv == 2'b10, "R5", "port0 served on fresh tie", pv, 2'b10);
    set_req(0, 0, 8, '0, 4'h3);
    step();
    check(pv == 2'b01, "R6", "held port1 served on retry", pv, 2'b01);
    drain();

    // Hash-only collision: line 0x41 (1^1=0) vs line 0x00, linear banks 1 vs 0
    set_req(0, 0, 8'h41, '0, 4'h4);
    set_req(1, 0, 8'h00, '0, 4'h5);
    step();
    check(pl_ready == 2'b11, "R1", "linear split banks", pl_ready, 3);
    drain();

    // Write on port 0 then read back on port 1
    set_req(0, 1, 5, 32'hCAFE_0005, 4'h6);
    drain();
    set_req(1, 0, 5, '0, 4'h7);
    drain();

    // Random traffic over the filled lines
    fresh_pairs = 0;
    fresh_coll  = 0;
    for (int n = 0; n < 2000; n++) begin
      for (int p = 0; p < 2; p++) begin
        if (!pv[p]) set_req(p, ($urandom % 4) == 0, int'($urandom % 256),
                            $urandom, TAG_W'($urandom));
      end
      step();
    end
    drain();
    repeat (3) @(negedge clk);
    check(fresh_pairs > 500, "R10", "fresh pair samples", fresh_pairs, 500);
    check(fresh_coll * 100 >= fresh_pairs * 17 && fresh_coll * 100 <= fresh_pairs * 33,
          "R10", "collision percent", (fresh_coll * 100) / (fresh_pairs + 1), 25);
    check(q0.size() == 0 && q1.size() == 0, "R7", "scoreboard empty",
          q0.size() + q1.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule